// File: doc/BRIEF.md
# Card Status Change Interrupt

This block watches the live condition pins of each removable-card socket: the two card-detect contacts, the card ready line, the two battery alarms and a general-purpose input. When one of these conditions changes, the block records the change in a per-socket event register. A host reads that register over a small register bus. Each event class can be enabled separately. A routing field chooses which of the host interrupt lines the socket drives, and the host lines are the OR of all socket requests.

Each socket also has a suspend bit. It is set at reset and must be cleared before the socket records events or raises an interrupt. Reading the event register hands the pending events to the host and clears them in the same access. An event that arrives in the same cycle as that read is kept, so no change is lost. The card counts as present only when both detect contacts are asserted. The detect event follows this combined state, not the individual contacts. Debouncing, battery sensing and power switching are done outside the block.

Top module: `card_chg_irq`

Bus address is `{socket, reg[1:0]}`. The registers are: 0 = event, 1 = control, 2 = live status, 3 = auxiliary. Event bits are [0] general input, [1] card presence, [2] ready, [3] battery warning, [4] battery dead.

## Requirements
- R1: A rising or falling transition of the ready, battery-warning, battery-dead or general input of an active socket sets that input's event bit at the next clock edge. A bit that is set stays set until it is cleared.
- R2: Event bit 1 is set only when the presence state changes. Presence is true when both detect pins are high. A transition of one detect pin that leaves presence unchanged sets no bit.
- R3: A bus read (req high, we low) returns its data on bus_rdata_o after the next clock edge. A read of the event register returns the pending bits and clears them at that same edge.
- R4: An event that occurs in the same cycle as a clearing read of its register remains set after the read.
- R5: Control register bits [4:0] enable the event classes in event-bit order. Bits [7:6] select the host line. The selected irq_o bit is high exactly while an enabled event bit is set and the socket is active. No other line is driven by that socket.
- R6: Writing zero to the control register removes that socket's interrupt from the next cycle on.
- R7: After a clearing read of the event register, the interrupt it caused is low from the cycle after the read request.
- R8: The status register reports live levels: [0] detect pin A, [1] detect pin B, [2] presence, [3] ready, [4] battery warning, [5] battery dead, [6] general input. Writes to it have no effect.
- R9: Auxiliary bit 0 is the suspend bit and reads 1 after reset. While it is set, no event is recorded and the socket drives no interrupt. Transitions that happen during suspend are not recorded after release. The other auxiliary bits read 0 whatever is written to them.
- R10: Sockets are independent. irq_o is the OR of all socket requests, so two sockets routed to one line keep it high until both are cleared.
- R11: After reset, the event and control registers read 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_a_i | input | NSOCK | Detect pin A per socket (synchronized) |
| det_b_i | input | NSOCK | Detect pin B per socket (synchronized) |
| rdy_i | input | NSOCK | Card ready level per socket |
| bwarn_i | input | NSOCK | Battery warning level per socket |
| bdead_i | input | NSOCK | Battery dead level per socket |
| gpi_i | input | NSOCK | General-purpose input level per socket |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | SOCK_W+2 | Socket index and register index |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid after the access edge |
| irq_o | output | NLINES | Host interrupt lines |

## Verification
Two functions can fall in the same clock edge: the clearing read of the event register and the recording of a new transition on one of its inputs. The bench raises the read request and flips the socket's ready pin at the same falling edge, so that both reach the same rising edge. It then judges two things. First, the returned data shows the state from before the edge. Second, a second read shows the ready bit still set. A similar overlap exists between suspend and a latched event: the interrupt must drop while the event itself stays readable.

// File: rtl/card_chg_pkg.sv
package card_chg_pkg;
  localparam int DW = 8;
  localparam int NEV = 5;

  localparam int EV_GPI   = 0;
  localparam int EV_DET   = 1;
  localparam int EV_RDY   = 2;
  localparam int EV_BWARN = 3;
  localparam int EV_BDEAD = 4;

  localparam logic [1:0] REG_EVT  = 2'd0;
  localparam logic [1:0] REG_CTL  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_AUX  = 2'd3;

  function automatic logic card_present(input logic a, input logic b);
    return a & b;
  endfunction

  function automatic logic [DW-1:0] ctl_mask(input int line_w);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < NEV; i++) m[i] = 1'b1;
    for (int i = 0; i < line_w; i++) m[DW-1-i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] status_byte(input logic a, input logic b,
                                                input logic rdy, input logic bw,
                                                input logic bd, input logic gp);
    return {1'b0, gp, bd, bw, rdy, card_present(a, b), b, a};
  endfunction
endpackage

// File: rtl/card_chg_edge.sv
module card_chg_edge #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] tog_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i[i];
    end
    assign tog_o[i] = lvl_i[i] ^ prev_q;
  end
endmodule

// File: rtl/card_chg_sock.sv
module card_chg_sock
  import card_chg_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int LINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_a_i,
  input  logic              det_b_i,
  input  logic              rdy_i,
  input  logic              bwarn_i,
  input  logic              bdead_i,
  input  logic              gpi_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [1:0]        reg_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     view_o,
  output logic [NLINES-1:0] irq_o
);
  localparam logic [DW-1:0] CTL_MASK = ctl_mask(LINE_W);

  logic              present;
  logic [NEV-1:0]    lvl, tog, new_evt, evt_q, evt_d, en;
  logic              susp_q;
  logic [DW-1:0]     ctl_q;
  logic [LINE_W-1:0] route;
  logic              wr_ctl, wr_aux, rd_clr, pending, fire;

  assign present = card_present(det_a_i, det_b_i);
  assign lvl = {bdead_i, bwarn_i, rdy_i, present, gpi_i};

  card_chg_edge #(.N(NEV)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (lvl),
    .tog_o (tog)
  );

  assign wr_ctl  = sel_i && we_i  && (reg_i == REG_CTL);
  assign wr_aux  = sel_i && we_i  && (reg_i == REG_AUX);
  assign rd_clr  = sel_i && !we_i && (reg_i == REG_EVT);
  assign new_evt = susp_q ? '0 : tog;
  assign evt_d   = (evt_q & ~{NEV{rd_clr}}) | new_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      ctl_q  <= '0;
      susp_q <= 1'b1;
    end else begin
      evt_q <= evt_d;
      if (wr_ctl) ctl_q  <= wdata_i & CTL_MASK;
      if (wr_aux) susp_q <= wdata_i[0];
    end
  end

  assign en      = ctl_q[NEV-1:0];
  assign route   = ctl_q[DW-1 -: LINE_W];
  assign pending = |(evt_q & en);
  assign fire    = pending && !susp_q;

  always_comb begin
    for (int i = 0; i < NLINES; i++)
      irq_o[i] = fire && (route == LINE_W'(i));
  end

  always_comb begin
    case (reg_i)
      REG_EVT:  view_o = {{(DW-NEV){1'b0}}, evt_q};
      REG_CTL:  view_o = ctl_q;
      REG_STAT: view_o = status_byte(det_a_i, det_b_i, rdy_i, bwarn_i, bdead_i, gpi_i);
      default:  view_o = {{(DW-1){1'b0}}, susp_q};
    endcase
  end

  // R3
  evt_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && new_evt == '0) |=> evt_q == '0);
  // R4
  evt_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && new_evt != '0) |=> ((evt_q & $past(new_evt)) == $past(new_evt)));
  // R9
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> irq_o == '0);
  // R9
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_q && !rd_clr) |=> evt_q == $past(evt_q));
  // R5
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));
  // R6
  ctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata_i == '0) |=> irq_o == '0);
  // R2
  det_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog[EV_DET] && !rd_clr) |=> evt_q[EV_DET] == $past(evt_q[EV_DET]));
endmodule

// File: rtl/card_chg_irq.sv
module card_chg_irq
  import card_chg_pkg::*;
#(
  parameter int NSOCK  = 4,
  parameter int NLINES = 4,
  localparam int SOCK_W = (NSOCK > 1) ? $clog2(NSOCK) : 1,
  localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int ADDR_W = SOCK_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSOCK-1:0]  det_a_i,
  input  logic [NSOCK-1:0]  det_b_i,
  input  logic [NSOCK-1:0]  rdy_i,
  input  logic [NSOCK-1:0]  bwarn_i,
  input  logic [NSOCK-1:0]  bdead_i,
  input  logic [NSOCK-1:0]  gpi_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic [NLINES-1:0] irq_o
);
  logic [SOCK_W-1:0] sock_idx;
  logic [1:0]        reg_idx;
  logic [DW-1:0]     views [NSOCK];
  logic [NLINES-1:0] reqs  [NSOCK];
  logic [DW-1:0]     rdata_q;

  assign sock_idx = bus_addr_i[ADDR_W-1:2];
  assign reg_idx  = bus_addr_i[1:0];

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    card_chg_sock #(.NLINES(NLINES), .LINE_W(LINE_W)) u_sock (
      .clk     (clk),
      .rst_n   (rst_n),
      .det_a_i (det_a_i[s]),
      .det_b_i (det_b_i[s]),
      .rdy_i   (rdy_i[s]),
      .bwarn_i (bwarn_i[s]),
      .bdead_i (bdead_i[s]),
      .gpi_i   (gpi_i[s]),
      .sel_i   (bus_req_i && (32'(sock_idx) == s)),
      .we_i    (bus_we_i),
      .reg_i   (reg_idx),
      .wdata_i (bus_wdata_i),
      .view_o  (views[s]),
      .irq_o   (reqs[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_req_i && !bus_we_i)
      rdata_q <= (32'(sock_idx) < NSOCK) ? views[sock_idx] : '0;
  end
  assign bus_rdata_o = rdata_q;

  always_comb begin
    irq_o = '0;
    for (int s = 0; s < NSOCK; s++) irq_o = irq_o | reqs[s];
  end
endmodule

// File: tb/card_chg_irq_tb.sv
module card_chg_irq_tb;
  localparam int NSOCK = 4;
  localparam int NLINES = 4;
  localparam int ADDR_W = 4;

  logic clk = 0, rst_n = 0;
  logic [NSOCK-1:0] det_a, det_b, rdy, bwarn, bdead, gpi;
  logic bus_req = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [NLINES-1:0] irq;
  logic [5:0] pins [NSOCK];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int s = 0; s < NSOCK; s++) begin
      det_a[s] = pins[s][0]; det_b[s] = pins[s][1]; rdy[s] = pins[s][2];
      bwarn[s] = pins[s][3]; bdead[s] = pins[s][4]; gpi[s] = pins[s][5];
    end
  end

  card_chg_irq #(.NSOCK(NSOCK), .NLINES(NLINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .det_a_i(det_a), .det_b_i(det_b), .rdy_i(rdy),
    .bwarn_i(bwarn), .bdead_i(bdead), .gpi_i(gpi), .bus_req_i(bus_req),
    .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq));

  typedef struct packed { logic [1:0] s; logic [5:0] p; logic [4:0] e; } vec_t;
  localparam vec_t VEC [10] = '{
    '{2'd0, 6'b000001, 5'h00}, '{2'd0, 6'b000011, 5'h02},
    '{2'd0, 6'b000111, 5'h04}, '{2'd0, 6'b000101, 5'h02},
    '{2'd0, 6'b101101, 5'h09}, '{2'd1, 6'b010000, 5'h10},
    '{2'd1, 6'b000000, 5'h10}, '{2'd2, 6'b111111, 5'h1F},
    '{2'd3, 6'b000010, 5'h00}, '{2'd2, 6'b111110, 5'h02}};

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic rd(input int s, input int r, output logic [7:0] d);
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = ADDR_W'(s * 4 + r);
    @(negedge clk); bus_req = 0; d = bus_rdata;
  endtask

  task automatic wr(input int s, input int r, input logic [7:0] v);
    @(negedge clk); bus_req = 1; bus_we = 1; bus_addr = ADDR_W'(s * 4 + r); bus_wdata = v;
    @(negedge clk); bus_req = 0; bus_we = 0;
  endtask

  task automatic set_pins(input int s, input logic [5:0] p);
    @(negedge clk); pins[s] = p;
    @(negedge clk);
  endtask

  function automatic logic [7:0] stat_of(input logic [5:0] p);
    return {1'b0, p[5], p[4], p[3], p[2], p[0] & p[1], p[1], p[0]};
  endfunction

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int s = 0; s < NSOCK; s++) pins[s] = 6'b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    check("R11 irq", 32'(irq), 0);
    rd(0, 0, d); check("R11 evt", 32'(d), 0);
    rd(0, 1, d); check("R11 ctl", 32'(d), 0);
    rd(0, 3, d); check("R9 suspend reset", 32'(d), 1);
    for (int s = 0; s < NSOCK; s++) wr(s, 3, 8'h00);

    // R1 R2 table walk
    foreach (VEC[i]) begin
      set_pins(int'(VEC[i].s), VEC[i].p);
      rd(int'(VEC[i].s), 0, d);
      check($sformatf("R1 R2 vec%0d", i), 32'(d), 32'(VEC[i].e));
    end

    // R5 R7 on socket 1, route 2, ready enabled
    wr(1, 1, 8'h84);
    set_pins(1, 6'b000100);
    check("R5 irq routed", 32'(irq), 32'h4);
    rd(1, 1, d); check("R5 ctl readback", 32'(d), 32'h84);
    rd(1, 0, d); check("R3 evt read", 32'(d), 32'h04);
    check("R7 irq after clear", 32'(irq), 0);
    // R6
    set_pins(1, 6'b000000);
    check("R6 irq before", 32'(irq), 32'h4);
    wr(1, 1, 8'h00);
    check("R6 irq after ctl zero", 32'(irq), 0);
    rd(1, 0, d); check("R3 evt pending", 32'(d), 32'h04);

    // R4 event in the same cycle as clearing read, socket 3
    @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = ADDR_W'(3 * 4 + 0);
    pins[3] = 6'b000110;
    @(negedge clk); bus_req = 0; d = bus_rdata;
    check("R4 read sees pre-edge", 32'(d), 0);
    rd(3, 0, d); check("R4 event kept", 32'(d), 32'h04);

    // R9 suspend on socket 3
    wr(3, 1, 8'hC1);
    set_pins(3, 6'b100110);
    check("R9 irq active", 32'(irq), 32'h8);
    wr(3, 3, 8'h01);
    check("R9 irq masked by suspend", 32'(irq), 0);
    rd(3, 0, d); check("R9 evt kept", 32'(d), 32'h01);
    set_pins(3, 6'b000110);
    wr(3, 3, 8'hFE);
    rd(3, 3, d); check("R9 aux other bits", 32'(d), 0);
    rd(3, 0, d); check("R9 suspended toggle lost", 32'(d), 0);
    check("R9 irq idle", 32'(irq), 0);

    // R10 two sockets on line 1
    wr(0, 1, 8'h48);
    wr(2, 1, 8'h44);
    set_pins(0, 6'b100101);
    set_pins(2, 6'b111010);
    check("R10 shared line", 32'(irq), 32'h2);
    rd(0, 0, d); check("R10 s0 evt", 32'(d), 32'h08);
    check("R10 line held by s2", 32'(irq), 32'h2);
    rd(2, 0, d); check("R10 s2 evt", 32'(d), 32'h04);
    check("R10 line idle", 32'(irq), 0);

    // R8 live status and ignored write
    for (int s = 0; s < NSOCK; s++) begin
      rd(s, 2, d); check($sformatf("R8 status s%0d", s), 32'(d), 32'(stat_of(pins[s])));
    end
    wr(2, 2, 8'hFF);
    rd(2, 2, d); check("R8 write ignored", 32'(d), 32'(stat_of(pins[2])));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule